// File: doc/BRIEF.md
# External Interrupt Source Aggregator

This block collects nine peripheral event signals and folds them into seven interrupt request lines for an 8051-style processor core. Every input goes through a two-stage synchronizer. An edge is found by comparing the synchronized level with its value one clock earlier. Each line then keeps a sticky pending flag that the hardware sets and software clears. A line drives its request output while its flag and its line enable are both set.

Lines 2, 4 and 6 are shared by several sources. Each source on a shared line has its own enable and its own sticky flag, and it sets the line flag as well. While any enabled source flag on a line is still set, software cannot clear that line's flag.

The edge sense of each line is as follows:
- Lines 0 and 1 react to rising edges.
- Lines 5 and 6 react to falling edges. The input is inverted and then detected on its rising edge.
- Line 4 reacts to both edges of the PLL lock signal, as two separate sources.
- Lines 2 and 3 each have a polarity bit that software can program. Both bits reset to falling-edge sense.

Software reads and writes the block through a small register file. Reads are combinational and writes are synchronous.

Top module: `ext_irq_hub`

## Requirements
- R1: After reset, every line flag, source flag, line enable and source enable is 0. The polarity register reads 2'b11 and `irq_req_o` is 0.
- R2: A rising edge on `dio_hi_i` sets line flag bit 0, and a rising edge on `dio_lo_i` sets bit 1. The flag can be read no more than four clocks after the input changes.
- R3: Polarity register bit 0 selects the edge for both collision inputs, and bit 1 selects the edge for `meng_busy_i` (line 3). A value of 1 means falling and 0 means rising. An edge of the other direction sets nothing.
- R4: A falling edge of `eep_busy_i` sets line flag bit 5. A rising edge sets nothing.
- R5: A rising edge of `pll_lock_i` sets source flag bit 2 and a falling edge sets source flag bit 3, each only when its source enable bit is set. Either event also sets line flag bit 4.
- R6: A detected edge on `fcol0_i` sets source flag bit 0, and one on `fcol1_i` sets source flag bit 1, each when enabled. Either event also sets line flag bit 2.
- R7: A falling edge of `xfer_busy_i` sets source flag bit 4, and a falling edge of `rtc_sec_i` sets source flag bit 5, each when enabled. Either event also sets line flag bit 6.
- R8: An event from a source whose enable bit is 0 sets neither its source flag nor its line flag.
- R9: `irq_req_o[i]` is 1 exactly when line flag i and line enable bit i (address 1) are both 1.
- R10: Writing to address 0 or address 2 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R11: A clear of line flag 2, 4 or 6 has no effect while an enabled source flag on that line is set.
- R12: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R13: The register map is as follows. Other addresses read 0.
  - Address 0: line flags, bit i for line i, 7 bits.
  - Address 1: line enables, 7 bits.
  - Address 2: source flags, 6 bits.
  - Address 3: source enables, 6 bits.
  - Address 4: polarity, 2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dio_hi_i | input | 1 | High-priority digital I/O event (line 0) |
| dio_lo_i | input | 1 | Low-priority digital I/O event (line 1) |
| fcol0_i | input | 1 | Flash write collision 0 (line 2) |
| fcol1_i | input | 1 | Flash write collision 1 (line 2) |
| meng_busy_i | input | 1 | Measurement engine busy (line 3) |
| pll_lock_i | input | 1 | PLL lock indicator (line 4, both edges) |
| eep_busy_i | input | 1 | EEPROM busy (line 5) |
| xfer_busy_i | input | 1 | Transfer busy (line 6) |
| rtc_sec_i | input | 1 | One-second real-time-clock tick (line 6) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| irq_req_o | output | 7 | Interrupt request per line |

## Verification
The directed tests drive each input through both edge directions, one at a time. This shows which direction sets a flag for each line, and under each setting of the polarity register. Other directed cases target specific behaviours:
- A clear written in the same cycle as a detected edge shows that the set takes priority.
- A partial W1C write shows that flags with a 0 data bit keep their value.
- Clearing a shared line before its source flag shows that the line flag is held.

Constrained random rounds then change several inputs at once and randomize the enables and polarity. These rounds show that simultaneous events on shared lines merge correctly and that the enables gate the source flags and requests independently.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
    localparam int NUM_LINES = 7;
    localparam int NUM_SRC   = 6;
    localparam int NUM_IN    = 9;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int POL_W     = 2;

    localparam logic [ADDR_W-1:0] A_LFLAG = 3'd0;
    localparam logic [ADDR_W-1:0] A_LEN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SFLAG = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_POL   = 3'd4;

    // synchronizer input positions
    localparam int IN_DIOH = 0;
    localparam int IN_DIOL = 1;
    localparam int IN_FC0  = 2;
    localparam int IN_FC1  = 3;
    localparam int IN_MENG = 4;
    localparam int IN_PLL  = 5;
    localparam int IN_EEP  = 6;
    localparam int IN_XFER = 7;
    localparam int IN_RTC  = 8;

    // source flag positions
    localparam int S_FC0  = 0;
    localparam int S_FC1  = 1;
    localparam int S_PLLR = 2;
    localparam int S_PLLF = 3;
    localparam int S_XFER = 4;
    localparam int S_RTC  = 5;
endpackage

// File: rtl/irq_sync_edge.sv
`timescale 1ns/1ps
module irq_sync_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~prev_q[i];
        assign fall_o[i] = ~sync_q[i] & prev_q[i];
    end
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] hold_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags_q[i] <= 1'b0;
            else if (set_i[i])  flags_q[i] <= 1'b1;
            else if (flags_q[i] && clr_i[i] && !hold_i[i])
                                flags_q[i] <= 1'b0;
        end
    end
    assign flags_o = flags_q;

    // R12: a set always lands, even with a clear in the same cycle
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R8: a flag only rises after a set request
    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));

    // R11: a held flag survives a clear
    a_r11_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags_q) & $past(hold_i) & ~flags_q) == '0));

    // R10: an unopposed clear takes effect
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(clr_i & ~set_i & ~hold_i) & flags_q) == '0));
endmodule

// File: rtl/ext_irq_hub.sv
`timescale 1ns/1ps
module ext_irq_hub
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dio_hi_i,
    input  logic              dio_lo_i,
    input  logic              fcol0_i,
    input  logic              fcol1_i,
    input  logic              meng_busy_i,
    input  logic              pll_lock_i,
    input  logic              eep_busy_i,
    input  logic              xfer_busy_i,
    input  logic              rtc_sec_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NUM_LINES-1:0] irq_req_o
);
    logic [NUM_IN-1:0]    raw_in, rise, fall;
    logic [NUM_SRC-1:0]   src_evt, src_set, src_clr, src_flag, src_en_q;
    logic [NUM_LINES-1:0] line_set, line_clr, line_hold, line_flag, line_en_q;
    logic [POL_W-1:0]     pol_q;
    logic                 fc0_evt, fc1_evt, meng_evt;
    logic                 unused_bits;

    assign raw_in = {rtc_sec_i, xfer_busy_i, eep_busy_i, pll_lock_i,
                     meng_busy_i, fcol1_i, fcol0_i, dio_lo_i, dio_hi_i};

    irq_sync_edge #(.W(NUM_IN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_in),
        .rise_o(rise), .fall_o(fall)
    );

    // programmable polarity: 1 = falling, 0 = rising
    assign fc0_evt  = pol_q[0] ? fall[IN_FC0]  : rise[IN_FC0];
    assign fc1_evt  = pol_q[0] ? fall[IN_FC1]  : rise[IN_FC1];
    assign meng_evt = pol_q[1] ? fall[IN_MENG] : rise[IN_MENG];

    always_comb begin
        src_evt         = '0;
        src_evt[S_FC0]  = fc0_evt;
        src_evt[S_FC1]  = fc1_evt;
        src_evt[S_PLLR] = rise[IN_PLL];
        src_evt[S_PLLF] = fall[IN_PLL];
        src_evt[S_XFER] = fall[IN_XFER];   // inverted, then rising detect
        src_evt[S_RTC]  = fall[IN_RTC];
    end
    assign src_set = src_evt & src_en_q;

    always_comb begin
        line_set    = '0;
        line_set[0] = rise[IN_DIOH];
        line_set[1] = rise[IN_DIOL];
        line_set[2] = src_set[S_FC0]  | src_set[S_FC1];
        line_set[3] = meng_evt;
        line_set[4] = src_set[S_PLLR] | src_set[S_PLLF];
        line_set[5] = fall[IN_EEP];        // inverted, then rising detect
        line_set[6] = src_set[S_XFER] | src_set[S_RTC];
    end

    always_comb begin
        line_hold    = '0;
        line_hold[2] = |(src_flag[S_FC1:S_FC0]   & src_en_q[S_FC1:S_FC0]);
        line_hold[4] = |(src_flag[S_PLLF:S_PLLR] & src_en_q[S_PLLF:S_PLLR]);
        line_hold[6] = |(src_flag[S_RTC:S_XFER]  & src_en_q[S_RTC:S_XFER]);
    end

    assign line_clr = (wr_en_i && wr_addr_i == A_LFLAG) ? wr_data_i[NUM_LINES-1:0] : '0;
    assign src_clr  = (wr_en_i && wr_addr_i == A_SFLAG) ? wr_data_i[NUM_SRC-1:0]   : '0;

    irq_flag_bank #(.W(NUM_LINES)) u_line_flags (
        .clk(clk), .rst_n(rst_n), .set_i(line_set), .clr_i(line_clr),
        .hold_i(line_hold), .flags_o(line_flag)
    );

    irq_flag_bank #(.W(NUM_SRC)) u_src_flags (
        .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr),
        .hold_i('0), .flags_o(src_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_en_q <= '0;
            src_en_q  <= '0;
            pol_q     <= '1;
        end else if (wr_en_i) begin
            unique case (wr_addr_i)
                A_LEN:   line_en_q <= wr_data_i[NUM_LINES-1:0];
                A_SEN:   src_en_q  <= wr_data_i[NUM_SRC-1:0];
                A_POL:   pol_q     <= wr_data_i[POL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_LFLAG: rd_data_o[NUM_LINES-1:0] = line_flag;
            A_LEN:   rd_data_o[NUM_LINES-1:0] = line_en_q;
            A_SFLAG: rd_data_o[NUM_SRC-1:0]   = src_flag;
            A_SEN:   rd_data_o[NUM_SRC-1:0]   = src_en_q;
            A_POL:   rd_data_o[POL_W-1:0]     = pol_q;
            default: rd_data_o = '0;
        endcase
    end

    assign irq_req_o = line_flag & line_en_q;
    assign unused_bits = ^wr_data_i[DATA_W-1:NUM_LINES];

    // R8: a disabled source never raises its flag
    a_r8_src_gated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_flag & ~$past(src_flag) & ~$past(src_en_q)) == '0));

    // R4: line 5 never rises after a rising edge of its input
    a_r4_eep_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise[IN_EEP] |=> !$rose(line_flag[5]));
endmodule

// File: tb/ext_irq_hub_test.sv
`timescale 1ns/1ps
module ext_irq_hub_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] din = '0;   // {rtc,xfer,eep,pll,meng,fc1,fc0,dio_lo,dio_hi}
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [6:0] irq_req;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ext_irq_hub uut (
        .clk(clk), .rst_n(rst_n),
        .dio_hi_i(din[0]), .dio_lo_i(din[1]), .fcol0_i(din[2]), .fcol1_i(din[3]),
        .meng_busy_i(din[4]), .pll_lock_i(din[5]), .eep_busy_i(din[6]),
        .xfer_busy_i(din[7]), .rtc_sec_i(din[8]),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_req_o(irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic drive(input int idx, input logic v);
        @(negedge clk);
        din[idx] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'hFF);
    endtask

    // expected {src_set[5:0], line_set[6:0]} for a stable change old -> new
    function automatic logic [12:0] model(input logic [8:0] o, input logic [8:0] n,
                                          input logic [1:0] pol, input logic [5:0] sen);
        logic [8:0] r, f;
        logic [5:0] s;
        logic [6:0] l;
        r = ~o & n;
        f = o & ~n;
        s[0] = (pol[0] ? f[2] : r[2]) & sen[0];
        s[1] = (pol[0] ? f[3] : r[3]) & sen[1];
        s[2] = r[5] & sen[2];
        s[3] = f[5] & sen[3];
        s[4] = f[7] & sen[4];
        s[5] = f[8] & sen[5];
        l[0] = r[0];
        l[1] = r[1];
        l[2] = s[0] | s[1];
        l[3] = pol[1] ? f[4] : r[4];
        l[4] = s[2] | s[3];
        l[5] = f[6];
        l[6] = s[4] | s[5];
        return {s, l};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R13 reset state and map
        rdchk("R1 line flags", 3'd0, 8'h00);
        rdchk("R1 line en",    3'd1, 8'h00);
        rdchk("R1 src flags",  3'd2, 8'h00);
        rdchk("R1 src en",     3'd3, 8'h00);
        rdchk("R1 polarity",   3'd4, 8'h03);
        rdchk("R13 unmapped",  3'd7, 8'h00);
        chk("R1 irq_req", {1'b0, irq_req}, 8'h00);

        // R2 rising on dio lines
        drive(0, 1'b1);
        drive(1, 1'b1);
        rdchk("R2 dio flags", 3'd0, 8'h03);
        chk("R9 no enable", {1'b0, irq_req}, 8'h00);
        wr(3'd1, 8'h01);
        chk("R9 enabled line 0", {1'b0, irq_req}, 8'h01);
        wr(3'd0, 8'h02);
        rdchk("R10 partial clear", 3'd0, 8'h01);
        wr(3'd0, 8'h01);
        rdchk("R10 full clear", 3'd0, 8'h00);
        chk("R9 cleared", {1'b0, irq_req}, 8'h00);
        drive(0, 1'b0);
        rdchk("R2 falling ignored", 3'd0, 8'h00);

        // R12 set beats clear in the same cycle
        @(negedge clk); din[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        rdchk("R12 set wins", 3'd0, 8'h01);
        wr(3'd0, 8'h01);

        // R4 line 5 falling only
        drive(6, 1'b1);
        rdchk("R4 rise ignored", 3'd0, 8'h00);
        drive(6, 1'b0);
        rdchk("R4 fall sets", 3'd0, 8'h20);
        wr(3'd0, 8'h20);

        // R3 line 3 polarity
        drive(4, 1'b1);
        rdchk("R3 falling mode ignores rise", 3'd0, 8'h00);
        drive(4, 1'b0);
        rdchk("R3 falling mode", 3'd0, 8'h08);
        wr(3'd0, 8'h08);
        wr(3'd4, 8'h01);
        drive(4, 1'b1);
        rdchk("R3 rising mode", 3'd0, 8'h08);
        wr(3'd0, 8'h08);
        drive(4, 1'b0);
        rdchk("R3 rising mode ignores fall", 3'd0, 8'h00);
        wr(3'd4, 8'h03);

        // R8 / R5 PLL sources
        drive(5, 1'b1);
        rdchk("R8 disabled src", 3'd2, 8'h00);
        rdchk("R8 disabled line", 3'd0, 8'h00);
        wr(3'd3, 8'h0C);
        drive(5, 1'b0);
        rdchk("R5 pll fall src", 3'd2, 8'h08);
        rdchk("R5 pll line", 3'd0, 8'h10);
        drive(5, 1'b1);
        rdchk("R5 pll rise src", 3'd2, 8'h0C);
        clear_all();
        rdchk("R10 pll cleared", 3'd0, 8'h00);

        // R6 / R11 collisions
        wr(3'd3, 8'h03);
        drive(2, 1'b1);
        rdchk("R3 collision rise ignored", 3'd2, 8'h00);
        drive(2, 1'b0);
        rdchk("R6 fc0 src", 3'd2, 8'h01);
        rdchk("R6 line 2", 3'd0, 8'h04);
        wr(3'd0, 8'h04);
        rdchk("R11 line held", 3'd0, 8'h04);
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h04);
        rdchk("R11 released", 3'd0, 8'h00);
        wr(3'd4, 8'h02);
        drive(3, 1'b1);
        rdchk("R6 fc1 rising mode", 3'd2, 8'h02);
        clear_all();

        // R7 line 6 sources
        wr(3'd3, 8'h30);
        drive(7, 1'b1);
        rdchk("R7 xfer rise ignored", 3'd2, 8'h00);
        drive(7, 1'b0);
        rdchk("R7 xfer src", 3'd2, 8'h10);
        rdchk("R7 line 6", 3'd0, 8'h40);
        drive(8, 1'b1);
        drive(8, 1'b0);
        rdchk("R7 rtc src", 3'd2, 8'h30);
        clear_all();
        wr(3'd4, 8'h03);

        // constrained random rounds
        begin
            logic [6:0] exp_l, len;
            logic [5:0] exp_s, sen;
            logic [1:0] pol;
            logic [12:0] m;
            logic [8:0] nv;
            exp_l = '0; exp_s = '0;
            for (int it = 0; it < 60; it++) begin
                sen = 6'($urandom);
                len = 7'($urandom);
                pol = 2'($urandom);
                wr(3'd3, {2'b0, sen});
                wr(3'd1, {1'b0, len});
                wr(3'd4, {6'b0, pol});
                nv = 9'($urandom);
                m = model(din, nv, pol, sen);
                @(negedge clk);
                din = nv;
                repeat (5) @(negedge clk);
                exp_l = exp_l | m[6:0];
                exp_s = exp_s | m[12:7];
                rdchk("R6 R5 R7 random lines", 3'd0, {1'b0, exp_l});
                rdchk("R8 random sources", 3'd2, {2'b0, exp_s});
                chk("R9 random requests", {1'b0, irq_req}, {1'b0, exp_l & len});
                if (it % 6 == 5) begin
                    clear_all();
                    exp_l = '0; exp_s = '0;
                    rdchk("R10 random clear", 3'd0, 8'h00);
                end
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule